// File: doc/BRIEF.md
# IO Freeze and Thaw Sequencer

This block drives the control lines of a set of identical general-purpose IO channels into and out of a frozen state. Each channel has five lines: slew enable, weak pull-up enable, tristate and bus-hold, which are all active low, and configuration-done, which is active high. A freeze or thaw request starts a sequence. The sequence visits the channels one at a time in ascending index order. Within each channel it applies a fixed series of line changes, and it keeps a minimum gap, measured in clock cycles, between consecutive steps.

The two directions do not follow the same order. Freezing first drops slew, pull-up and tristate, then drops bus-hold and configuration-done. Thawing first raises bus-hold and configuration-done, then raises pull-up and tristate, and releases slew enable last. When a request is accepted, the block also switches the control source to the sequencer. When the last channel is finished, the block raises a one-cycle done pulse. Each channel reports whether it is frozen or thawed.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset, every channel has slew, pull-up, tristate and bus-hold low, configuration-done low and its frozen flag set (1). busy_o, done_o and sw_src_o are all 0.
- R2: While the block is idle, a request that is high at a clock edge is accepted at that edge. If freeze_req_i and thaw_req_i are both high, freeze wins. busy_o goes high from that edge. sw_src_o goes high at that edge and stays high until reset.
- R3: Freeze of one channel has two steps. Step one drives slew, pull-up and tristate low together. GAP_CYC cycles later, step two drives bus-hold low and configuration-done low and sets the frozen flag.
- R4: Thaw of one channel has three steps. Step one drives bus-hold and configuration-done high. GAP_CYC cycles later, step two drives pull-up and tristate high. GAP_CYC cycles after that, step three drives slew high and clears the frozen flag.
- R5: GAP_CYC is the larger of 1 and the rounded-up quotient GAP_NS / CLK_PERIOD_NS. With the defaults (20 ns gap, 10 ns clock) it is 2.
- R6: Channels are processed in ascending order, and only the active channel changes. The first step of channel 0 is visible one cycle after the accepting edge. Each later channel's first step follows one cycle after the previous channel's last step.
- R7: A request that arrives while busy_o is high is ignored. The running sequence continues unchanged, and nothing starts after it.
- R8: done_o is high for exactly one cycle. That cycle is the same one in which the last channel's final step becomes visible, and busy_o is already low in it.
- R9: Running a sequence on channels that are already in the target state leaves every output line unchanged. The sequence still completes with its done pulse at the normal time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_req_i | input | 1 | Request to freeze all channels |
| thaw_req_i | input | 1 | Request to thaw all channels |
| sw_src_o | output | 1 | Control source set to the sequencer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| frozen_o | output | NUM_CH | Per-channel frozen flag |
| slew_n_o | output | NUM_CH | Slew enable, active low |
| pullup_n_o | output | NUM_CH | Weak pull-up enable, active low |
| tristate_n_o | output | NUM_CH | Tristate, active low |
| bushold_n_o | output | NUM_CH | Bus-hold, active low |
| cfg_done_o | output | NUM_CH | Configuration done, active high |

## Verification
The bench records the exact cycle in which every line of every channel changes, and the number of times it changes. It then compares those records with the step schedule. A design that merges steps, inverts the freeze order, or skips the gap would show a wrong cycle. A design that leaves a channel out, or touches one early, would show an extra or missing change. A freeze request is injected in the middle of a thaw; a design that does not ignore it would refreeze channels or restart, and its done pulse would move. Simultaneous requests and a repeated freeze check the priority rule and the no-change case, including whether the done pulse still lines up with the final step.

// File: rtl/io_frz_pkg.sv
package io_frz_pkg;
  typedef enum logic { OP_FREEZE = 1'b0, OP_THAW = 1'b1 } op_e;
  typedef enum logic [1:0] { PH_A = 2'd0, PH_B = 2'd1, PH_C = 2'd2 } phase_e;
endpackage

// File: rtl/io_frz_gap_timer.sv
module io_frz_gap_timer #(
  parameter int GAP_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
  localparam logic [W-1:0] LOAD_VAL = W'(GAP_CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);
  a_r5_no_reload_while_counting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expired_o |-> !load_i);
endmodule

// File: rtl/io_frz_chan.sv
module io_frz_chan
  import io_frz_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   apply_i,
  input  op_e    op_i,
  input  phase_e phase_i,
  output logic   slew_n_o,
  output logic   pullup_n_o,
  output logic   tristate_n_o,
  output logic   bushold_n_o,
  output logic   cfg_done_o,
  output logic   frozen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slew_n_o     <= 1'b0;
      pullup_n_o   <= 1'b0;
      tristate_n_o <= 1'b0;
      bushold_n_o  <= 1'b0;
      cfg_done_o   <= 1'b0;
      frozen_o     <= 1'b1;
    end else if (apply_i) begin
      if (op_i == OP_FREEZE) begin
        case (phase_i)
          PH_A: begin
            slew_n_o     <= 1'b0;
            pullup_n_o   <= 1'b0;
            tristate_n_o <= 1'b0;
          end
          default: begin
            bushold_n_o <= 1'b0;
            cfg_done_o  <= 1'b0;
            frozen_o    <= 1'b1;
          end
        endcase
      end else begin
        case (phase_i)
          PH_A: begin
            bushold_n_o <= 1'b1;
            cfg_done_o  <= 1'b1;
          end
          PH_B: begin
            pullup_n_o   <= 1'b1;
            tristate_n_o <= 1'b1;
          end
          default: begin
            slew_n_o <= 1'b1;
            frozen_o <= 1'b0;
          end
        endcase
      end
    end
  end

  // freeze: bus-hold drops only once drivers are already parked
  a_r3_hold_after_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bushold_n_o) |-> (!slew_n_o && !pullup_n_o && !tristate_n_o));
  // thaw: slew released last
  a_r4_slew_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slew_n_o) |-> (bushold_n_o && pullup_n_o && tristate_n_o && cfg_done_o));
endmodule

// File: rtl/io_freeze_seq.sv
module io_freeze_seq
  import io_frz_pkg::*;
#(
  parameter int NUM_CH        = 3,
  parameter int CLK_PERIOD_NS = 10,
  parameter int GAP_NS        = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freeze_req_i,
  input  logic              thaw_req_i,
  output logic              sw_src_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [NUM_CH-1:0] frozen_o,
  output logic [NUM_CH-1:0] slew_n_o,
  output logic [NUM_CH-1:0] pullup_n_o,
  output logic [NUM_CH-1:0] tristate_n_o,
  output logic [NUM_CH-1:0] bushold_n_o,
  output logic [NUM_CH-1:0] cfg_done_o
);
  localparam int GAP_RAW = (GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int CW      = (NUM_CH < 2) ? 1 : $clog2(NUM_CH);
  localparam logic [CW-1:0] LAST_CH = CW'(NUM_CH - 1);

  logic          busy_q, done_q, src_q;
  op_e           op_q;
  phase_e        ph_q;
  logic [CW-1:0] ch_q;
  logic          expired, step, last_ph;
  logic [NUM_CH-1:0] apply;

  assign last_ph = (op_q == OP_FREEZE) ? (ph_q == PH_B) : (ph_q == PH_C);
  assign step    = busy_q && expired;

  io_frz_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (step && !last_ph),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      src_q  <= 1'b0;
      op_q   <= OP_FREEZE;
      ph_q   <= PH_A;
      ch_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (freeze_req_i || thaw_req_i) begin
          busy_q <= 1'b1;
          src_q  <= 1'b1;
          op_q   <= freeze_req_i ? OP_FREEZE : OP_THAW;
          ph_q   <= PH_A;
          ch_q   <= '0;
        end
      end else if (step) begin
        if (last_ph) begin
          ph_q <= PH_A;
          if (ch_q == LAST_CH) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end else begin
          ph_q <= phase_e'(ph_q + 2'd1);
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign apply[c] = step && (ch_q == CW'(c));
    io_frz_chan u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .apply_i      (apply[c]),
      .op_i         (op_q),
      .phase_i      (ph_q),
      .slew_n_o     (slew_n_o[c]),
      .pullup_n_o   (pullup_n_o[c]),
      .tristate_n_o (tristate_n_o[c]),
      .bushold_n_o  (bushold_n_o[c]),
      .cfg_done_o   (cfg_done_o[c]),
      .frozen_o     (frozen_o[c])
    );
  end

  assign sw_src_o = src_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  a_r2_src_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_q |=> src_q);
  a_r6_one_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(apply));
  a_r7_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !step) |=> busy_q);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
endmodule

// File: tb/tb_io_freeze_seq.sv
module tb_io_freeze_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int G = 2;       // ceil(20 ns / 10 ns), at least 1
  localparam int NS = 40;

  logic clk = 1'b0, rst_n = 1'b0, frz_req = 1'b0, thw_req = 1'b0;
  logic sw_src, busy, done;
  logic [NCH-1:0] frozen, slew_n, pu_n, tri_n, bh_n, cfg;

  int checks = 0, errors = 0;
  int chg [NCH][6];
  int nchg[NCH][6];
  int done_at, done_cnt, busy_first;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_freeze_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .freeze_req_i(frz_req), .thaw_req_i(thw_req),
    .sw_src_o(sw_src), .busy_o(busy), .done_o(done), .frozen_o(frozen),
    .slew_n_o(slew_n), .pullup_n_o(pu_n), .tristate_n_o(tri_n),
    .bushold_n_o(bh_n), .cfg_done_o(cfg)
  );

  // bit order: 0 slew, 1 pull-up, 2 tristate, 3 bus-hold, 4 cfg-done, 5 frozen
  function automatic logic [5:0] snap(int c);
    return {frozen[c], cfg[c], bh_n[c], tri_n[c], pu_n[c], slew_n[c]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue request(s) at a negedge, sample NS cycles, record change cycles
  task automatic run(bit f, bit t, int inject);
    logic [5:0] prev[NCH];
    for (int c = 0; c < NCH; c++) begin
      prev[c] = snap(c);
      for (int s = 0; s < 6; s++) begin chg[c][s] = -1; nchg[c][s] = 0; end
    end
    done_at = -1; done_cnt = 0; busy_first = 0;
    frz_req = f; thw_req = t;
    for (int k = 0; k < NS; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 0) begin busy_first = busy; frz_req = 1'b0; thw_req = 1'b0; end
      for (int c = 0; c < NCH; c++) begin
        logic [5:0] cur;
        cur = snap(c);
        for (int s = 0; s < 6; s++)
          if (cur[s] != prev[c][s]) begin
            if (chg[c][s] < 0) chg[c][s] = k;
            nchg[c][s]++;
          end
        prev[c] = cur;
      end
      if (done) begin
        if (done_at < 0) done_at = k;
        done_cnt++;
        chk(!busy, "R8 busy low at done", busy, 0);
      end
      if (k == inject)     frz_req = 1'b1;
      if (k == inject + 1) frz_req = 1'b0;
    end
  endtask

  task automatic test_reset;
    for (int c = 0; c < NCH; c++)
      chk(snap(c) == 6'b100000, "R1 reset lines", snap(c), 6'b100000);
    chk(!busy && !done && !sw_src, "R1 reset status", {busy, done, sw_src}, 0);
  endtask

  task automatic test_thaw(int inject, string tag);
    int a;
    run(1'b0, 1'b1, inject);
    chk(busy_first, {tag, " R2 busy at accept"}, busy_first, 1);
    chk(sw_src, {tag, " R2 source switched"}, sw_src, 1);
    a = 1;
    for (int c = 0; c < NCH; c++) begin
      chk(chg[c][3] == a && chg[c][4] == a, {tag, " R4 R6 step1 cycle"}, chg[c][3], a);
      chk(chg[c][1] == a + G && chg[c][2] == a + G, {tag, " R4 R5 step2 cycle"}, chg[c][1], a + G);
      chk(chg[c][0] == a + 2*G && chg[c][5] == a + 2*G, {tag, " R4 R5 step3 cycle"}, chg[c][0], a + 2*G);
      for (int s = 0; s < 6; s++)
        chk(nchg[c][s] == 1, {tag, " R6 R7 single change"}, nchg[c][s], 1);
      chk(snap(c) == 6'b011111, {tag, " R4 thawed lines"}, snap(c), 6'b011111);
      a = a + 2*G + 1;
    end
    chk(done_at == a - 1 && done_cnt == 1, {tag, " R8 done timing"}, done_at, a - 1);
    chk(!busy, {tag, " R7 idle after"}, busy, 0);
  endtask

  task automatic test_freeze(bit both);
    int a;
    run(1'b1, both, -10);
    a = 1;
    for (int c = 0; c < NCH; c++) begin
      chk(chg[c][0] == a && chg[c][1] == a && chg[c][2] == a, "R3 R6 step1 cycle", chg[c][0], a);
      chk(chg[c][3] == a + G && chg[c][4] == a + G && chg[c][5] == a + G, "R3 R5 step2 cycle", chg[c][3], a + G);
      chk(snap(c) == 6'b100000, "R2 R3 frozen lines", snap(c), 6'b100000);
      a = a + G + 1;
    end
    chk(done_at == a - 1 && done_cnt == 1, "R8 freeze done timing", done_at, a - 1);
  endtask

  task automatic test_refreeze;
    int n;
    run(1'b1, 1'b0, -10);
    n = 0;
    for (int c = 0; c < NCH; c++) for (int s = 0; s < 6; s++) n += nchg[c][s];
    chk(n == 0, "R9 no line change", n, 0);
    chk(done_at == NCH*(G+1) && done_cnt == 1, "R9 done still pulses", done_at, NCH*(G+1));
    chk(sw_src, "R2 source stays set", sw_src, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_thaw(-10, "plain");
    test_freeze(1'b0);
    test_thaw(4, "inject");     // R7: freeze request mid-thaw
    test_freeze(1'b1);          // R2: both requests, freeze wins
    test_refreeze();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule